// File: doc/BRIEF.md
# Skewed Two-Way Cache Tag Lookup

This block is the tag side of a two-way cache in which the two ways do not share a set index. Way 0 is addressed directly by the low bits of the line address. Way 1 is addressed by a folded hash of the address. Two lines that fight over one way-0 entry therefore usually sit in different way-1 entries. The block holds a valid bit, a tag and a recently-used bit for every entry of each way. It takes one request at a time and reports hit or miss. On a hit it also reports the hitting way, and on a miss it reports the way to replace. It then waits for the fill that installs the missed line.

A request is accepted in `ST_IDLE` (transition *accept*, to `ST_LOOKUP`). The way-1 index is registered on acceptance, so both ways are compared in `ST_LOOKUP`, one cycle after the request. From `ST_LOOKUP` a hit returns to `ST_IDLE` (*hit_done*) and a miss moves to `ST_REFILL` (*miss_wait*). A fill strobe in `ST_REFILL` writes the chosen way and returns to `ST_IDLE` (*fill_done*). A flush from any state enters `ST_SWEEP` (*flush_start*). That state clears one index of both ways per cycle and returns to `ST_IDLE` after the last index (*sweep_done*). A flush that arrives during a sweep starts the sweep again from index 0.

Top module: `skew_tag_lookup`

## Requirements
- R1: Way 0 uses index `addr[IDX_W-1:0]` and stores `addr[ADDR_W-1:IDX_W]`. A way-0 hit reports `hit_way` = 0.
- R2: Way 1 uses index `addr[IDX_W-1:0] ^ addr[2*IDX_W-1:IDX_W]` and stores the whole line address. A way-1 hit reports `hit_way` = 1. If both ways match, way 0 is reported.
- R3: `req_ready` is high only in `ST_IDLE` while `flush` is low. An accepted request makes `resp_valid` high on the next cycle only.
- R4: `hit` and `miss` are high only together with `resp_valid`, and exactly one of them is high then. `hit` means a valid candidate entry holds a matching tag.
- R5: On a miss, an invalid candidate is the victim. Way 0 is checked first, then way 1.
- R6: On a miss with both candidates valid, the victim is the candidate whose recently-used bit is clear.
- R7: On a miss with both candidates valid and equal recently-used bits, the victim is the value of a one-bit toggle. The toggle is 0 after reset, flips each time it decides a victim, and is not changed by a flush.
- R8: A hit or a fill sets the recently-used bit of the touched way's entry. It also clears the recently-used bit of the other way's candidate entry for the same address.
- R9: After a miss, `req_ready` stays low until `fill_valid` is sampled. The fill writes way `fill_way` at that way's own index for `fill_addr`, and the block is in `ST_IDLE` on the next cycle.
- R10: A flush sampled in `ST_IDLE` holds `req_ready` low for exactly 2^IDX_W cycles. It invalidates every entry of both ways and clears their recently-used bits.
- R11: After reset, `req_ready` is high, `resp_valid` is low, and all entries are invalid.
- R12: `fill_valid` outside `ST_REFILL` changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Start invalidating all entries |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_addr | input | ADDR_W | Line address to look up |
| resp_valid | output | 1 | Lookup result present |
| hit | output | 1 | Address found |
| miss | output | 1 | Address not found |
| hit_way | output | 1 | Way holding the address |
| victim_way | output | 1 | Way to refill on a miss |
| fill_valid | input | 1 | Fill strobe |
| fill_way | input | 1 | Way written by the fill |
| fill_addr | input | ADDR_W | Line address installed by the fill |

## Verification
The bench aims at addresses that share a way-0 entry but differ in the hashed way-1 entry. A design that hashed the wrong bits, or used the way-0 index for both ways, would report misses or the wrong `hit_way` for such lines. It also builds two chosen states: one with exactly one stale recently-used bit, and two where both bits are equal. A shared per-set replacement record or a toggle that never flips would then name the wrong victim. Flush length, stalling until the fill, and a stray fill strobe in idle are also checked. A sweep that is one entry short, a fill taken early, or an unguarded write port would leave the following lookups hitting.

// File: rtl/skew_cache_pkg.sv
package skew_cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_REFILL,
        ST_SWEEP
    } lookup_state_e;
endpackage

// File: rtl/skew_index_hash.sv
module skew_index_hash #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx_direct,
    output logic [IDX_W-1:0]  idx_skewed
);
    // direct index: low bits; skewed index: low bits folded with the next slice
    for (genvar b = 0; b < IDX_W; b++) begin : g_fold
        assign idx_direct[b] = addr[b];
        assign idx_skewed[b] = addr[b] ^ addr[b + IDX_W];
    end
endmodule

// File: rtl/skew_tag_way.sv
module skew_tag_way #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_ru,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             ru_set_en,
    input  logic [IDX_W-1:0] ru_set_idx,
    input  logic             ru_clr_en,
    input  logic [IDX_W-1:0] ru_clr_idx,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] ru_q;
    logic [TAG_W-1:0] tag_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic hit_inv;
        logic hit_wr;
        logic hit_set;
        logic hit_clr;

        assign hit_inv = inv_en    && (inv_idx    == IDX_W'(e));
        assign hit_wr  = wr_en     && (wr_idx     == IDX_W'(e));
        assign hit_set = ru_set_en && (ru_set_idx == IDX_W'(e));
        assign hit_clr = ru_clr_en && (ru_clr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[e] <= 1'b0;
                ru_q[e]  <= 1'b0;
            end else begin
                if (hit_inv) begin
                    vld_q[e] <= 1'b0;
                end else if (hit_wr) begin
                    vld_q[e] <= 1'b1;
                end

                if (hit_inv) begin
                    ru_q[e] <= 1'b0;
                end else if (hit_set) begin
                    ru_q[e] <= 1'b1;
                end else if (hit_clr) begin
                    ru_q[e] <= 1'b0;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (hit_wr) begin
                tag_q[e] <= wr_tag;
            end
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_ru    = ru_q[rd_idx];
endmodule

// File: rtl/skew_victim_pick.sv
module skew_victim_pick (
    input  logic valid0,
    input  logic valid1,
    input  logic ru0,
    input  logic ru1,
    input  logic toggle,
    output logic victim,
    output logic tie_used
);
    always_comb begin
        tie_used = 1'b0;
        if (!valid0) begin
            victim = 1'b0;
        end else if (!valid1) begin
            victim = 1'b1;
        end else if (ru0 != ru1) begin
            // the way used recently keeps its line
            victim = ru0;
        end else begin
            victim   = toggle;
            tie_used = 1'b1;
        end
    end
endmodule

// File: rtl/skew_tag_lookup.sv
module skew_tag_lookup
    import skew_cache_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic              hit,
    output logic              miss,
    output logic              hit_way,
    output logic              victim_way,
    input  logic              fill_valid,
    input  logic              fill_way,
    input  logic [ADDR_W-1:0] fill_addr
);
    localparam int              DEPTH    = 1 << IDX_W;
    localparam int              TAG0_W   = ADDR_W - IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    lookup_state_e state_q, state_d;

    logic [ADDR_W-1:0] q_addr;
    logic [IDX_W-1:0]  q_idx0, q_idx1;
    logic [IDX_W-1:0]  sweep_q;
    logic              tog_q;

    logic [IDX_W-1:0]  r_idx0, r_idx1, f_idx0, f_idx1;
    logic              v0, v1, u0, u1;
    logic [TAG0_W-1:0] t0;
    logic [ADDR_W-1:0] t1;
    logic              match0, match1, any_match;
    logic              in_lookup, in_sweep, look_hit, look_miss;
    logic              accept, fill_fire;
    logic              pick, tie_used;
    logic              touch0, touch1;
    logic [IDX_W-1:0]  set0_idx, set1_idx;

    skew_index_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_req_hash (
        .addr       (req_addr),
        .idx_direct (r_idx0),
        .idx_skewed (r_idx1)
    );

    skew_index_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fill_hash (
        .addr       (fill_addr),
        .idx_direct (f_idx0),
        .idx_skewed (f_idx1)
    );

    assign in_lookup = (state_q == ST_LOOKUP);
    assign in_sweep  = (state_q == ST_SWEEP);
    assign accept    = req_valid && req_ready;
    assign fill_fire = (state_q == ST_REFILL) && fill_valid && !flush;

    assign match0    = v0 && (t0 == q_addr[ADDR_W-1:IDX_W]);
    assign match1    = v1 && (t1 == q_addr);
    assign any_match = match0 || match1;
    assign look_hit  = in_lookup && any_match;
    assign look_miss = in_lookup && !any_match;

    // touched way: the hit way in lookup, the fill way in refill
    assign touch0   = (look_hit && match0) || (fill_fire && !fill_way);
    assign touch1   = (look_hit && !match0) || (fill_fire && fill_way);
    assign set0_idx = in_lookup ? q_idx0 : f_idx0;
    assign set1_idx = in_lookup ? q_idx1 : f_idx1;

    skew_tag_way #(.IDX_W(IDX_W), .TAG_W(TAG0_W)) u_way0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (q_idx0),
        .rd_valid   (v0),
        .rd_tag     (t0),
        .rd_ru      (u0),
        .wr_en      (fill_fire && !fill_way),
        .wr_idx     (f_idx0),
        .wr_tag     (fill_addr[ADDR_W-1:IDX_W]),
        .ru_set_en  (touch0),
        .ru_set_idx (set0_idx),
        .ru_clr_en  (touch1),
        .ru_clr_idx (set0_idx),
        .inv_en     (in_sweep),
        .inv_idx    (sweep_q)
    );

    skew_tag_way #(.IDX_W(IDX_W), .TAG_W(ADDR_W)) u_way1 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (q_idx1),
        .rd_valid   (v1),
        .rd_tag     (t1),
        .rd_ru      (u1),
        .wr_en      (fill_fire && fill_way),
        .wr_idx     (f_idx1),
        .wr_tag     (fill_addr),
        .ru_set_en  (touch1),
        .ru_set_idx (set1_idx),
        .ru_clr_en  (touch0),
        .ru_clr_idx (set1_idx),
        .inv_en     (in_sweep),
        .inv_idx    (sweep_q)
    );

    skew_victim_pick u_pick (
        .valid0   (v0),
        .valid1   (v1),
        .ru0      (u0),
        .ru1      (u1),
        .toggle   (tog_q),
        .victim   (pick),
        .tie_used (tie_used)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (flush)          state_d = ST_SWEEP;
                else if (req_valid) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (flush)          state_d = ST_SWEEP;
                else if (any_match) state_d = ST_IDLE;
                else                state_d = ST_REFILL;
            end
            ST_REFILL: begin
                if (flush)           state_d = ST_SWEEP;
                else if (fill_valid) state_d = ST_IDLE;
            end
            ST_SWEEP: begin
                if (!flush && sweep_q == LAST_IDX) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_idx0  <= '0;
            q_idx1  <= '0;
            sweep_q <= '0;
            tog_q   <= 1'b0;
        end else begin
            if (accept) begin
                q_addr <= req_addr;
                q_idx0 <= r_idx0;
                q_idx1 <= r_idx1;
            end
            if (flush) begin
                sweep_q <= '0;
            end else if (in_sweep) begin
                sweep_q <= sweep_q + 1'b1;
            end
            if (look_miss && tie_used) begin
                tog_q <= !tog_q;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        hit        = 1'b0;
        miss       = 1'b0;
        hit_way    = 1'b0;
        victim_way = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = !flush;
            end
            ST_LOOKUP: begin
                resp_valid = 1'b1;
                hit        = any_match;
                miss       = !any_match;
                hit_way    = any_match && !match0;
                victim_way = !any_match && pick;
            end
            ST_REFILL, ST_SWEEP: begin
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/skew_tag_lookup_chk.sv
module skew_tag_lookup_chk (
    input logic clk,
    input logic rst_n,
    input logic flush,
    input logic req_valid,
    input logic req_ready,
    input logic resp_valid,
    input logic hit,
    input logic miss
);
    // R3
    resp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    // R3
    resp_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid && req_ready));

    // R4
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (hit != miss));

    // R4
    result_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !(hit || miss));

    // R9
    miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && miss) |=> !req_ready);

    // R10
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !req_ready);
endmodule

bind skew_tag_lookup skew_tag_lookup_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .hit        (hit),
    .miss       (miss)
);

// File: tb/test_skew_tag_lookup.sv
module test_skew_tag_lookup;
    localparam int AW = 16;
    localparam int IW = 4;
    localparam int DP = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          resp_valid, hit, miss, hit_way, victim_way;
    logic          fill_valid = 1'b0;
    logic          fill_way = 1'b0;
    logic [AW-1:0] fill_addr = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model
    bit            mv0 [DP];
    bit            mv1 [DP];
    bit            mr0 [DP];
    bit            mr1 [DP];
    logic [AW-IW-1:0] mt0 [DP];
    logic [AW-1:0] mt1 [DP];
    bit            mtog = 1'b0;

    always #2 clk = !clk;

    skew_tag_lookup #(.ADDR_W(AW), .IDX_W(IW)) i_skew_tag_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .resp_valid (resp_valid),
        .hit        (hit),
        .miss       (miss),
        .hit_way    (hit_way),
        .victim_way (victim_way),
        .fill_valid (fill_valid),
        .fill_way   (fill_way),
        .fill_addr  (fill_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < DP; k++) begin
            mv0[k] = 1'b0; mv1[k] = 1'b0; mr0[k] = 1'b0; mr1[k] = 1'b0;
        end
    endtask

    task automatic model_touch(input bit w, input int i0, input int i1);
        if (!w) begin mr0[i0] = 1'b1; mr1[i1] = 1'b0; end
        else    begin mr1[i1] = 1'b1; mr0[i0] = 1'b0; end
    endtask

    task automatic lookup(input logic [AW-1:0] a, input int delay);
        int i0 = int'(a[IW-1:0]);
        int i1 = int'(a[IW-1:0] ^ a[2*IW-1:IW]);
        bit h0 = mv0[i0] && (mt0[i0] == a[AW-1:IW]);
        bit h1 = mv1[i1] && (mt1[i1] == a);
        bit vic;
        bit tie = 1'b0;
        string why;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 resp_valid after accept", resp_valid, 1);
        if (h0 || h1) begin
            chk("R4 hit", hit, 1);
            chk("R4 miss", miss, 0);
            chk(h0 ? "R1 hit_way" : "R2 hit_way", hit_way, h0 ? 0 : 1);
            model_touch(!h0, i0, i1);   // R8
            @(negedge clk);
            chk("R3 resp_valid one cycle", resp_valid, 0);
            chk("R3 ready after hit", req_ready, 1);
        end else begin
            chk("R4 hit", hit, 0);
            chk("R4 miss", miss, 1);
            if (!mv0[i0])               begin vic = 1'b0; why = "R5 victim"; end
            else if (!mv1[i1])          begin vic = 1'b1; why = "R5 victim"; end
            else if (mr0[i0] != mr1[i1]) begin vic = mr0[i0]; why = "R6 victim"; end
            else begin vic = mtog; tie = 1'b1; why = "R7 victim"; end
            chk(why, victim_way, vic);
            if (tie) mtog = !mtog;
            for (int d = 0; d <= delay; d++) begin
                @(negedge clk);
                chk("R9 stall before fill", req_ready, 0);
            end
            fill_valid = 1'b1;
            fill_way   = vic;
            fill_addr  = a;
            @(negedge clk);
            fill_valid = 1'b0;
            chk("R9 idle after fill", req_ready, 1);
            if (!vic) begin mv0[i0] = 1'b1; mt0[i0] = a[AW-1:IW]; end
            else      begin mv1[i1] = 1'b1; mt1[i1] = a; end
            model_touch(vic, i0, i1);   // R8
        end
    endtask

    task automatic do_flush();
        int cnt = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        while (!req_ready && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        chk("R10 flush length", cnt, DP);
        model_clear();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lf = 16'hACE1;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 ready after reset", req_ready, 1);
        chk("R11 no resp after reset", resp_valid, 0);
        chk("R11 no hit after reset", hit, 0);

        // R11: first lookup sees empty arrays
        lookup(16'h0012, 0);          // R5 way 0 empty
        lookup(16'h0012, 0);          // R1 hit way 0
        lookup(16'h0322, 1);          // R5 shares way-0 entry, way 1 empty
        lookup(16'h0322, 0);          // R2 hit way 1
        lookup(16'h0055, 0);          // clears stale bit of way-1 entry 0
        lookup(16'h0522, 2);          // R7 tie, toggle 0
        lookup(16'h0912, 0);          // R5 way 1 entry 3
        lookup(16'h0722, 0);          // R7 tie, toggle 1
        lookup(16'h0B22, 0);          // R6 differing bits
        lookup(16'h0722, 0);
        lookup(16'h0055, 0);

        // R10: flush then everything misses
        do_flush();
        lookup(16'h0722, 0);
        lookup(16'h0012, 0);

        // R12: stray fill in idle
        do_flush();
        @(negedge clk);
        fill_valid = 1'b1;
        fill_way   = 1'b0;
        fill_addr  = 16'h0055;
        @(negedge clk);
        fill_valid = 1'b0;
        chk("R12 ready unchanged by stray fill", req_ready, 1);
        fill_way   = 1'b1;
        fill_addr  = 16'h0055;
        fill_valid = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
        lookup(16'h0055, 0);          // R12 must miss

        // mixed traffic against the model
        for (int n = 0; n < 300; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            lookup({6'b0, lf[1:0], 2'b0, lf[3:2], 2'b0, lf[5:4]}, int'(lf[7:6]) % 3);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule